// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block runs on the host side of an asynchronous parallel NOR flash. It decides when an embedded program or erase operation inside the device has finished. After a `start` pulse it asks a separate flash bus engine for status reads, taken in pairs. It compares the toggle bit (bit 6) of the second read in a pair with the same bit from the first read. The block uses the timeout flag (bit 5) only to arrange one last confirming pair. When it is done, it reports a one-cycle success or failure pulse.

A pair whose toggle bit does not change means the operation has completed, and the device returns array data on the next read. If the bit is still changing after the timeout flag has risen, or after a programmable number of plain pairs, the poller writes the reset command (0xF0) to the device. It raises the failure pulse only once that write is acknowledged.

States: `ST_IDLE` waits for `start`. `ST_RD_FIRST` and `ST_RD_SECOND` hold a read request until it is acknowledged. `ST_JUDGE` evaluates the pair. `ST_ABORT_WR` holds the reset-command write. `ST_PASS` and `ST_FAIL` each emit one result pulse.

Transitions:
- IDLE to RD_FIRST on `start`.
- RD_FIRST to RD_SECOND on ack.
- RD_SECOND to JUDGE on ack.
- JUDGE to PASS when the toggle bit is steady.
- JUDGE to RD_FIRST when the toggle bit changes and either the timeout flag is newly seen, or the flag is low and the limit has not been reached.
- JUDGE to ABORT_WR when the toggle bit changes and either this was the recheck pair or the limit has been reached.
- ABORT_WR to FAIL on ack.
- PASS or FAIL to IDLE.

Top module: `flash_done_poller`

## Requirements
- R1: While reset is asserted and right after it, `busy`, `bus_req`, `done_ok` and `done_fail` are all low.
- R2: A `start` pulse in idle raises `busy`, and the first bus request is a read (`bus_we` = 0).
- R3: When bit 6 of the two reads in a pair is equal, the poller gives `done_ok` without issuing any write. Only bits 6 and 5 of a status byte affect the result.
- R4: When bit 6 differs, bit 5 of the second read is low and the limit is not reached, the poller starts another read pair.
- R5: When bit 6 differs and bit 5 of the second read is high, the poller performs exactly one more pair. If bit 6 is equal in that pair, the result is `done_ok`.
- R6: When bit 6 still differs in the recheck pair, the poller issues one write with data 0xF0. `done_fail` follows only after that write is acknowledged.
- R7: `max_pairs` caps the plain pairs (bit 6 differs, bit 5 low, no recheck pending). When the N-th such pair still toggles, the failure path of R6 is taken. A `max_pairs` of 0 acts as 1. A pair that sees bit 5 high goes to recheck even at the limit.
- R8: `start` has no effect while `busy` is high. No extra reads occur, and the poller stays idle after its result.
- R9: `done_ok` and `done_fail` are never high together, each lasts one cycle, and `busy` is low in the next cycle.
- R10: A request holds `bus_req` and `bus_we` steady until the cycle in which `bus_ack` is high. Each such cycle completes exactly one transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin polling (taken only in idle) |
| max_pairs | input | CW | Limit on plain read pairs before failure |
| bus_req | output | 1 | Transfer request to the flash bus engine |
| bus_we | output | 1 | 1 = write (reset command), 0 = status read |
| bus_wdata | output | DW | Write data (0xF0 during the reset write) |
| bus_ack | input | 1 | Transfer complete; read data valid in this cycle |
| bus_rdata | input | DW | Status byte returned by a read |
| busy | output | 1 | Poller not idle |
| done_ok | output | 1 | One-cycle success pulse |
| done_fail | output | 1 | One-cycle failure pulse |

## Verification
In one evaluation cycle the timeout recheck and the iteration limit can both apply. This happens when the pair that reaches `max_pairs` is also the first to show bit 5 high. The bench provokes this with a limit of 2 and a second pair that toggles with bit 5 set, followed by a steady pair. It judges the result by the outcome (success), by the read count (six), and by the absence of any reset write. A stray `start` during a busy poll is also driven, and it must leave the read count and the idle state after the result unchanged.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
    localparam int TOG_BIT = 6;
    localparam int TMO_BIT = 5;
    localparam logic [7:0] RESET_CMD = 8'hF0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_FIRST,
        ST_RD_SECOND,
        ST_JUDGE,
        ST_ABORT_WR,
        ST_PASS,
        ST_FAIL
    } poll_state_t;
endpackage

// File: rtl/poll_pair_cmp.sv
module poll_pair_cmp
    import flash_poll_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_first,
    input  logic          cap_second,
    input  logic [DW-1:0] rdata,
    output logic          toggled,
    output logic          tmo_seen
);
    logic first_tog;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_tog <= 1'b0;
            toggled   <= 1'b0;
            tmo_seen  <= 1'b0;
        end else begin
            if (cap_first) begin
                first_tog <= rdata[TOG_BIT];
            end
            if (cap_second) begin
                toggled  <= rdata[TOG_BIT] ^ first_tog;
                tmo_seen <= rdata[TMO_BIT];
            end
        end
    end
endmodule

// File: rtl/poll_iter_ctr.sv
module poll_iter_ctr #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic [CW-1:0] max_pairs,
    output logic          at_limit
);
    logic [CW-1:0] cnt;
    logic [CW:0]   pairs_done;

    assign pairs_done = {1'b0, cnt} + {{CW{1'b0}}, 1'b1};
    assign at_limit   = pairs_done >= {1'b0, max_pairs};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> cnt != '1);
endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
    import flash_poll_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] max_pairs,
    output logic          bus_req,
    output logic          bus_we,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_ack,
    input  logic [DW-1:0] bus_rdata,
    output logic          busy,
    output logic          done_ok,
    output logic          done_fail
);
    poll_state_t state, nxt;
    logic recheck;
    logic toggled, tmo_seen, at_limit;
    logic cap_first, cap_second, ctr_clr, ctr_inc;

    assign cap_first  = (state == ST_RD_FIRST)  && bus_ack;
    assign cap_second = (state == ST_RD_SECOND) && bus_ack;
    assign ctr_clr    = (state == ST_IDLE) && start;
    assign ctr_inc    = (state == ST_JUDGE) && toggled && !recheck
                        && !tmo_seen && !at_limit;

    poll_pair_cmp #(.DW(DW)) u_cmp (
        .clk(clk), .rst_n(rst_n),
        .cap_first(cap_first), .cap_second(cap_second),
        .rdata(bus_rdata),
        .toggled(toggled), .tmo_seen(tmo_seen)
    );

    poll_iter_ctr #(.CW(CW)) u_ctr (
        .clk(clk), .rst_n(rst_n),
        .clr(ctr_clr), .inc(ctr_inc),
        .max_pairs(max_pairs),
        .at_limit(at_limit)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (start) nxt = ST_RD_FIRST;
            ST_RD_FIRST:  if (bus_ack) nxt = ST_RD_SECOND;
            ST_RD_SECOND: if (bus_ack) nxt = ST_JUDGE;
            ST_JUDGE: begin
                if (!toggled)      nxt = ST_PASS;
                else if (recheck)  nxt = ST_ABORT_WR;
                else if (tmo_seen) nxt = ST_RD_FIRST;
                else if (at_limit) nxt = ST_ABORT_WR;
                else               nxt = ST_RD_FIRST;
            end
            ST_ABORT_WR:  if (bus_ack) nxt = ST_FAIL;
            ST_PASS:      nxt = ST_IDLE;
            ST_FAIL:      nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            recheck <= 1'b0;
        end else begin
            state <= nxt;
            if (ctr_clr) begin
                recheck <= 1'b0;
            end else if (state == ST_JUDGE && toggled && tmo_seen && !recheck) begin
                recheck <= 1'b1;
            end
        end
    end

    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_wdata = '0;
        busy      = (state != ST_IDLE);
        done_ok   = 1'b0;
        done_fail = 1'b0;
        unique case (state)
            ST_RD_FIRST, ST_RD_SECOND: bus_req = 1'b1;
            ST_ABORT_WR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_wdata = DW'(RESET_CMD);
            end
            ST_PASS: done_ok   = 1'b1;
            ST_FAIL: done_fail = 1'b1;
            default: ;
        endcase
    end

    p_one_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_ok && done_fail));
    p_ok_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_ok |=> !done_ok && !busy);
    p_fail_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_fail |=> !done_fail && !busy);
    p_hold_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_we));
    p_fail_after_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_fail |-> $past(bus_req && bus_we && bus_ack));
    p_ok_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_ok |-> !$past(bus_we));
    p_busy_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done_ok && !done_fail |=> busy);
endmodule

// File: tb/test_flash_done_poller.sv
module test_flash_done_poller;
    localparam int DW = 8;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] max_pairs = '0;
    logic          bus_req, bus_we, busy, done_ok, done_fail;
    logic [DW-1:0] bus_wdata;
    logic          bus_ack = 1'b0;
    logic [DW-1:0] bus_rdata = '0;

    always #5 clk = ~clk;

    flash_done_poller #(.DW(DW), .CW(CW)) i_flash_done_poller (
        .clk(clk), .rst_n(rst_n), .start(start), .max_pairs(max_pairs),
        .bus_req(bus_req), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .busy(busy), .done_ok(done_ok), .done_fail(done_fail)
    );

    typedef struct {
        bit    fail;
        int    reads;
        int    writes;
        string tag;
    } exp_t;

    exp_t       exp_q[$];
    logic [7:0] stat_q[$];
    logic [7:0] scr[$];
    int n_cmp = 0;
    int n_bad = 0;
    int reads_seen = 0;
    int writes_seen = 0;
    int lat = 0;
    bit ended = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // bus engine model: acknowledges after a rotating latency of 0..2 cycles
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && bus_req) begin
                logic we0;
                we0 = bus_we;
                repeat (lat) @(negedge clk);
                chk(bus_req === 1'b1 && bus_we === we0, "R10 request held",
                    int'(bus_req), 1);
                if (we0) begin
                    writes_seen++;
                    chk(bus_wdata == 8'hF0, "R6 reset data", int'(bus_wdata), 'hF0);
                end else begin
                    reads_seen++;
                    bus_rdata = (stat_q.size() > 0) ? stat_q.pop_front() : 8'h00;
                end
                bus_ack = 1'b1;
                lat = (lat + 1) % 3;
                @(negedge clk);
                bus_ack = 1'b0;
            end
        end
    end

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && (done_ok || done_fail)) begin
                exp_t e;
                chk(!(done_ok && done_fail), "R9 exclusive results", 1, 0);
                if (exp_q.size() == 0) begin
                    chk(0, "R8 unexpected result", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(done_fail == e.fail, {e.tag, " outcome fail"}, int'(done_fail), int'(e.fail));
                    chk(reads_seen == e.reads, {e.tag, " read count"}, reads_seen, e.reads);
                    chk(writes_seen == e.writes, {e.tag, " write count"}, writes_seen, e.writes);
                end
                reads_seen  = 0;
                writes_seen = 0;
                @(negedge clk);
                chk(!busy && !done_ok && !done_fail, "R9 one-cycle pulse", int'(busy), 0);
            end
        end
    end

    task automatic add(input logic [7:0] b);
        scr.push_back(b);
    endtask

    task automatic run_case(input string tag, input int mx, input bit poke);
        exp_t e;
        int i = 0, pairs = 0;
        bit rc = 0, fin = 0;
        e.fail = 0; e.writes = 0; e.tag = tag;
        while (!fin) begin
            logic [7:0] a, c;
            a = (i < scr.size()) ? scr[i] : 8'h00;
            c = (i + 1 < scr.size()) ? scr[i+1] : 8'h00;
            i += 2;
            if (a[6] == c[6]) fin = 1;
            else if (rc) begin e.fail = 1; fin = 1; end
            else if (c[5]) rc = 1;
            else begin
                pairs++;
                if (pairs >= ((mx == 0) ? 1 : mx)) begin e.fail = 1; fin = 1; end
            end
        end
        e.reads = i;
        if (e.fail) e.writes = 1;
        foreach (scr[k]) stat_q.push_back(scr[k]);
        scr.delete();
        exp_q.push_back(e);
        max_pairs = CW'(mx);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1 && bus_req === 1'b1 && bus_we === 1'b0, "R2 first request is read",
            int'(bus_we), 0);
        if (poke) begin
            repeat (3) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait (exp_q.size() == 0);
        repeat (4) @(negedge clk);
        chk(!busy && !bus_req, {tag, " R8 idle after result"}, int'(busy), 0);
        stat_q.delete();
    endtask

    initial begin
        repeat (2) @(negedge clk);
        chk(!busy && !bus_req && !done_ok && !done_fail, "R1 in reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !bus_req && !done_ok && !done_fail, "R1 after reset", int'(busy), 0);

        add(8'h00); add(8'h00);                           run_case("R3 steady", 4, 0);
        add(8'h9F); add(8'hDF); add(8'h1F); add(8'h1F);   run_case("R3 R4 other bits ignored", 4, 0);
        add(8'h00); add(8'h40); add(8'h40); add(8'h40);   run_case("R4 second pair", 4, 0);
        add(8'h00); add(8'h60); add(8'h40); add(8'h40);   run_case("R5 recheck ok", 4, 0);
        add(8'h00); add(8'h60); add(8'h00); add(8'h40);   run_case("R6 recheck fail", 4, 0);
        add(8'h40); add(8'h20); add(8'h60); add(8'h00);   run_case("R6 toggling recheck with bit5 low", 9, 0);
        for (int k = 0; k < 3; k++) begin add(8'h00); add(8'h40); end
        run_case("R7 limit three", 3, 0);
        add(8'h00); add(8'h40);                           run_case("R7 limit one", 1, 0);
        add(8'h00); add(8'h40);                           run_case("R7 limit zero", 0, 0);
        add(8'h00); add(8'h40); add(8'h00); add(8'h60); add(8'h40); add(8'h40);
        run_case("R5 R7 timeout at limit", 2, 0);
        for (int k = 0; k < 5; k++) begin add(8'h00); add(8'h40); end
        add(8'h40); add(8'h40);
        run_case("R8 start while busy", 20, 1);

        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule